// File: doc/BRIEF.md
# H-Bridge Switch Sequencer With Dead Time

The block drives the four gates of one full H-bridge: a high and a low switch on leg A, and a high and a low switch on leg B. A motor current controller gives a bridge mode request (off, charge, slow decay or fast decay) and a bit for the current direction. The block turns that request into a gate pattern. A pattern for one direction of current is the mirror of the pattern for the other direction, except slow decay. Slow decay closes both low switches whatever the direction.

The bridge never switches directly from one conducting pattern to a different one. Every change to a new conducting pattern first holds all four gates open for a fixed number of clock cycles (`DEAD_CYC`). Turning the bridge off takes effect at once. If a different request arrives while a dead interval is running, the new request becomes the target and the interval starts again.

Two inputs force all gates open in the same cycle they are sampled: a low enable and a high overtemperature input. The overtemperature input also pulls an active-low protection flag low. When a forcing input releases, the bridge re-enters through a full dead interval.

Top module: `hbridge_sequencer`

## Requirements
- R1: While reset is asserted, and at the first sample after it, all four gates are off and `prot_n` is high.
- R2: The mode encoding is 00 off, 01 charge, 10 slow decay, 11 fast decay. With `dir_neg`=0, the driven patterns are: charge = leg-A high with leg-B low; slow = both lows; fast = leg-B high with leg-A low.
- R3: With `dir_neg`=1, the driven patterns are: charge = leg-B high with leg-A low; slow = both lows; fast = leg-A high with leg-B low.
- R4: A request for mode off opens all gates at the next clock edge, with no dead interval.
- R5: When the request maps to a conducting pattern other than the one driven, the gates are all off for exactly `DEAD_CYC` clock cycles, counted from the edge that samples the request. The new pattern appears on the following edge. This also holds when the bridge starts from off.
- R6: Dead time depends only on the gate pattern. A direction flip in charge or fast mode changes the pattern, so it gets a dead interval. A flip in slow decay, or a request that maps to the same gates (for example charge positive and fast negative), keeps the gates on with no gap.
- R7: If a different conducting request is sampled during a dead interval, that request replaces the pending one and the full `DEAD_CYC` count restarts from that edge.
- R8: `enable` low forces all gates off in the same cycle. Once enable returns, the requested pattern is driven only after a full dead interval.
- R9: `overtemp` high forces all gates off in the same cycle, and `prot_n` goes low at the next edge. After `overtemp` clears, `prot_n` returns high at the next edge, and driving resumes after a full dead interval.
- R10: The high and low switch of the same leg are never on together. Any conducting output is one of the three legal patterns.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | High allows the bridge to conduct; low forces all gates off |
| overtemp | input | 1 | Overtemperature indication; high forces all gates off |
| mode_req | input | 2 | Requested bridge mode (00 off, 01 charge, 10 slow, 11 fast) |
| dir_neg | input | 1 | Current direction; 0 positive, 1 negative |
| gate_hi_a | output | 1 | Leg-A high-side gate |
| gate_hi_b | output | 1 | Leg-B high-side gate |
| gate_lo_a | output | 1 | Leg-A low-side gate |
| gate_lo_b | output | 1 | Leg-B low-side gate |
| prot_n | output | 1 | Active-low overtemperature flag |

## Verification
The assertions check the following on every clock:
- no leg ever has both switches closed;
- a conducting output is always a legal pattern;
- one conducting pattern never replaces another without an open gap;
- every such gap lasts at least the dead interval;
- the forcing inputs keep the gates open, and the protection flag tracks overtemperature.

Some properties only the bench scenarios can show, because they depend on what was requested and when. These are the exact gate pattern for each mode and direction, the exact length of the gap, the restart of the count when a request changes mid-interval, and the cases where a direction flip leaves the gates untouched.

// File: rtl/hbs_pkg.sv
package hbs_pkg;

    typedef enum logic [1:0] {
        MODE_OFF    = 2'b00,
        MODE_CHARGE = 2'b01,
        MODE_SLOW   = 2'b10,
        MODE_FAST   = 2'b11
    } mode_e;

    typedef struct packed {
        logic hi_a;
        logic hi_b;
        logic lo_a;
        logic lo_b;
    } gates_t;

    localparam gates_t GATES_OFF = '0;

    typedef enum logic {
        ST_DRIVE = 1'b0,
        ST_DEAD  = 1'b1
    } seq_st_e;

    typedef struct packed {
        seq_st_e st;
        gates_t  cur;
        gates_t  tgt;
    } seq_t;

endpackage

// File: rtl/hbs_pattern_map.sv
module hbs_pattern_map
    import hbs_pkg::*;
(
    input  mode_e  mode_i,
    input  logic   dir_neg_i,
    output gates_t gates_o
);

    always_comb begin
        gates_o = GATES_OFF;
        case (mode_i)
            MODE_CHARGE: begin
                if (!dir_neg_i) begin
                    gates_o.hi_a = 1'b1;
                    gates_o.lo_b = 1'b1;
                end else begin
                    gates_o.hi_b = 1'b1;
                    gates_o.lo_a = 1'b1;
                end
            end
            MODE_SLOW: begin
                gates_o.lo_a = 1'b1;
                gates_o.lo_b = 1'b1;
            end
            MODE_FAST: begin
                if (!dir_neg_i) begin
                    gates_o.hi_b = 1'b1;
                    gates_o.lo_a = 1'b1;
                end else begin
                    gates_o.hi_a = 1'b1;
                    gates_o.lo_b = 1'b1;
                end
            end
            default: gates_o = GATES_OFF;
        endcase
    end

endmodule

// File: rtl/hbs_dead_timer.sv
module hbs_dead_timer #(
    parameter int unsigned DEAD_CYC = 15
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    output logic expire_o
);

    localparam int unsigned CW = $clog2(DEAD_CYC + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = CW'(DEAD_CYC);
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expire_o = (cnt_q == CW'(1));

endmodule

// File: rtl/hbs_fault_gate.sv
module hbs_fault_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic enable_i,
    input  logic overtemp_i,
    output logic force_off_o,
    output logic prot_n_o
);

    logic prot_n_d, prot_n_q;

    assign force_off_o = !enable_i || overtemp_i;

    always_comb begin
        prot_n_d = !overtemp_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prot_n_q <= 1'b1;
        end else begin
            prot_n_q <= prot_n_d;
        end
    end

    assign prot_n_o = prot_n_q;

endmodule

// File: rtl/hbridge_sequencer.sv
module hbridge_sequencer
    import hbs_pkg::*;
#(
    parameter int unsigned DEAD_CYC = 15
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enable,
    input  logic       overtemp,
    input  logic [1:0] mode_req,
    input  logic       dir_neg,
    output logic       gate_hi_a,
    output logic       gate_hi_b,
    output logic       gate_lo_a,
    output logic       gate_lo_b,
    output logic       prot_n
);

    gates_t req_g;
    gates_t drive_g;
    logic   force_off;
    logic   tmr_load;
    logic   tmr_expire;
    seq_t   s_d, s_q;

    hbs_pattern_map u_map (
        .mode_i    (mode_e'(mode_req)),
        .dir_neg_i (dir_neg),
        .gates_o   (req_g)
    );

    hbs_dead_timer #(
        .DEAD_CYC (DEAD_CYC)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (tmr_load),
        .expire_o (tmr_expire)
    );

    hbs_fault_gate u_fault (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable_i    (enable),
        .overtemp_i  (overtemp),
        .force_off_o (force_off),
        .prot_n_o    (prot_n)
    );

    always_comb begin
        s_d      = s_q;
        tmr_load = 1'b0;
        if (force_off) begin
            s_d.st  = ST_DRIVE;
            s_d.cur = GATES_OFF;
            s_d.tgt = GATES_OFF;
        end else begin
            case (s_q.st)
                ST_DRIVE: begin
                    if (req_g != s_q.cur) begin
                        s_d.cur = GATES_OFF;
                        if (req_g != GATES_OFF) begin
                            s_d.st   = ST_DEAD;
                            s_d.tgt  = req_g;
                            tmr_load = 1'b1;
                        end
                    end
                end
                ST_DEAD: begin
                    if (req_g == GATES_OFF) begin
                        s_d.st  = ST_DRIVE;
                        s_d.cur = GATES_OFF;
                        s_d.tgt = GATES_OFF;
                    end else if (req_g != s_q.tgt) begin
                        s_d.tgt  = req_g;
                        tmr_load = 1'b1;
                    end else if (tmr_expire) begin
                        s_d.st  = ST_DRIVE;
                        s_d.cur = s_q.tgt;
                    end
                end
                default: s_d = s_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: ST_DRIVE, cur: GATES_OFF, tgt: GATES_OFF};
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        drive_g = GATES_OFF;
        if (!force_off && s_q.st == ST_DRIVE) begin
            drive_g = s_q.cur;
        end
    end

    assign gate_hi_a = drive_g.hi_a;
    assign gate_hi_b = drive_g.hi_b;
    assign gate_lo_a = drive_g.lo_a;
    assign gate_lo_b = drive_g.lo_b;

endmodule

// File: rtl/hbs_checker.sv
module hbs_checker #(
    parameter int unsigned DEAD_CYC = 15
) (
    input logic clk,
    input logic rst_n,
    input logic enable,
    input logic overtemp,
    input logic gate_hi_a,
    input logic gate_hi_b,
    input logic gate_lo_a,
    input logic gate_lo_b,
    input logic prot_n
);

    localparam int unsigned RW = $clog2(DEAD_CYC + 2);

    logic [3:0]    g;
    logic [RW-1:0] off_run_q;

    assign g = {gate_hi_a, gate_hi_b, gate_lo_a, gate_lo_b};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            off_run_q <= '0;
        end else if (g != 4'b0000) begin
            off_run_q <= '0;
        end else if (off_run_q < RW'(DEAD_CYC)) begin
            off_run_q <= off_run_q + RW'(1);
        end
    end

    p_leg_a_exclusive_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(gate_hi_a && gate_lo_a));

    p_leg_b_exclusive_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(gate_hi_b && gate_lo_b));

    p_legal_pattern_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (g != 4'b0000) |-> (g == 4'b1001 || g == 4'b0011 || g == 4'b0110));

    p_no_direct_swap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(g) != 4'b0000 && g != 4'b0000) |-> (g == $past(g)));

    p_gap_length_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (g != 4'b0000 && $past(g) == 4'b0000) |-> (off_run_q >= RW'(DEAD_CYC)));

    p_enable_forces_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |-> (g == 4'b0000));

    p_overtemp_forces_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        overtemp |-> (g == 4'b0000));

    p_flag_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (prot_n == !$past(overtemp)));

endmodule

bind hbridge_sequencer hbs_checker #(.DEAD_CYC(DEAD_CYC)) u_hbs_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .overtemp  (overtemp),
    .gate_hi_a (gate_hi_a),
    .gate_hi_b (gate_hi_b),
    .gate_lo_a (gate_lo_a),
    .gate_lo_b (gate_lo_b),
    .prot_n    (prot_n)
);

// File: tb/sim_hbridge_sequencer.sv
module sim_hbridge_sequencer;

    localparam int DT = 15;
    // gate order {hi_a, hi_b, lo_a, lo_b}
    localparam logic [3:0] G_OFF  = 4'b0000;
    localparam logic [3:0] G_AHBL = 4'b1001; // charge+, fast-
    localparam logic [3:0] G_LOWS = 4'b0011; // slow
    localparam logic [3:0] G_BHAL = 4'b0110; // charge-, fast+

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic       overtemp = 1'b0;
    logic [1:0] mode_req = 2'b00;
    logic       dir_neg = 1'b0;
    logic       gate_hi_a, gate_hi_b, gate_lo_a, gate_lo_b, prot_n;

    typedef struct {
        logic [3:0] g;
        logic       pn;
        string      rq;
    } exp_t;

    exp_t q[$];
    int   n_cmp = 0;
    int   n_bad = 0;
    bit   done = 1'b0;

    always #2 clk = ~clk;

    hbridge_sequencer #(.DEAD_CYC(DT)) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .overtemp  (overtemp),
        .mode_req  (mode_req),
        .dir_neg   (dir_neg),
        .gate_hi_a (gate_hi_a),
        .gate_hi_b (gate_hi_b),
        .gate_lo_a (gate_lo_a),
        .gate_lo_b (gate_lo_b),
        .prot_n    (prot_n)
    );

    task automatic step(input logic [3:0] g, input logic pn, input string rq);
        exp_t e;
        e.g = g;
        e.pn = pn;
        e.rq = rq;
        q.push_back(e);
        @(negedge clk);
    endtask

    task automatic steps(input int n, input logic [3:0] g, input logic pn, input string rq);
        for (int i = 0; i < n; i++) step(g, pn, rq);
    endtask

    // monitor: samples 1 ns after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                exp_t e;
                logic [3:0] got;
                e = q.pop_front();
                got = {gate_hi_a, gate_hi_b, gate_lo_a, gate_lo_b};
                n_cmp++;
                // R10 also covered: a leg conflict can never equal a legal expectation
                if (got !== e.g || prot_n !== e.pn) begin
                    n_bad++;
                    $display("FAIL %s: got gates=%b prot_n=%b, expected gates=%b prot_n=%b",
                             e.rq, got, prot_n, e.g, e.pn);
                end
            end
        end
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            done = 1'b1;
            n_bad++;
            $display("FAIL watchdog: got no end of run, expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        steps(2, G_OFF, 1'b1, "R1 reset state");
        rst_n = 1'b1;
        enable = 1'b1;
        mode_req = 2'b01; dir_neg = 1'b0;
        steps(DT, G_OFF, 1'b1, "R5 gap from off");
        steps(3, G_AHBL, 1'b1, "R2 charge positive");
        mode_req = 2'b10;
        steps(DT, G_OFF, 1'b1, "R5 gap charge to slow");
        steps(2, G_LOWS, 1'b1, "R2 slow positive");
        dir_neg = 1'b1;
        steps(2, G_LOWS, 1'b1, "R6 slow flip no gap / R3 slow negative");
        mode_req = 2'b11;
        steps(DT, G_OFF, 1'b1, "R5 gap slow to fast");
        steps(2, G_AHBL, 1'b1, "R3 fast negative");
        mode_req = 2'b01; dir_neg = 1'b0;
        steps(2, G_AHBL, 1'b1, "R6 same gates no gap");
        dir_neg = 1'b1;
        steps(DT, G_OFF, 1'b1, "R6 charge flip gap");
        steps(2, G_BHAL, 1'b1, "R3 charge negative");
        mode_req = 2'b11; dir_neg = 1'b0;
        steps(1, G_BHAL, 1'b1, "R2 fast positive");
        mode_req = 2'b00;
        steps(2, G_OFF, 1'b1, "R4 off immediate");
        mode_req = 2'b10;
        steps(5, G_OFF, 1'b1, "R7 pending slow");
        mode_req = 2'b01;
        steps(DT, G_OFF, 1'b1, "R7 restarted gap");
        steps(2, G_AHBL, 1'b1, "R7 replaced target");
        enable = 1'b0;
        steps(3, G_OFF, 1'b1, "R8 enable low off");
        enable = 1'b1;
        steps(DT, G_OFF, 1'b1, "R8 gap after enable");
        steps(2, G_AHBL, 1'b1, "R8 resume");
        overtemp = 1'b1;
        steps(3, G_OFF, 1'b0, "R9 overtemp off and flag");
        overtemp = 1'b0;
        steps(DT, G_OFF, 1'b1, "R9 flag clear and gap");
        steps(2, G_AHBL, 1'b1, "R9 resume");
        @(posedge clk);
        #3;
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule